// File: doc/BRIEF.md
# Restartable Vector Element Sequencer

This block walks an element index upward from a starting point to a programmable vector length. Each step sends one element operation to an external compute pipeline. At most a fixed number of elements may be outstanding at once, held in a small window of slots. Results may come back in any order. They are written to the register file strictly in index order, so the committed part of the vector is always an unbroken run that ends just below the commit index.

An interrupt or cancel request is always honoured while a vector is running. New issue stops in the same cycle. The block then discards every element that has not been written back and pulls the loop index back to the first uncommitted element. It signals the pipelines to drop their work, and it acknowledges the request. The commit index is visible on its own output, so it can be saved with the rest of the context. A later resume reloads that index, and issue restarts from it with an empty window.

There are five states. ST_IDLE waits for start or resume. ST_RUN issues and retires elements. ST_FLUSH discards the window and rolls back the issue index. ST_ACK acknowledges the interrupt. ST_FINISH pulses done. The transitions are:
- ST_IDLE to ST_RUN on start with a non-zero length, or on resume below the length.
- ST_IDLE to ST_FINISH on start with length zero, or on resume at or past the length.
- ST_RUN to ST_FLUSH on an interrupt request. This takes priority.
- ST_RUN to ST_FINISH when the last element is written back.
- ST_FLUSH to ST_ACK.
- ST_ACK to ST_IDLE.
- ST_FINISH to ST_IDLE.

Top module: `vec_elem_seq`

## Requirements
- R1: After reset, and whenever the block is idle, busy, iss_valid, wb_valid, done, flush and intr_ack are all low. After reset saved_idx is 0.
- R2: On start, elements are issued in ascending order from 0. On resume, they are issued in ascending order from resume_idx. Each index is issued once. iss_slot equals the index modulo WIN. Nothing is issued at or past the vector length. A length above MAX_VL is treated as MAX_VL.
- R3: Writebacks occur in strictly ascending, gap-free index order, at most one per cycle. Each carries the data of the completion for that element and happens only after that completion. wb_idx equals saved_idx in the writeback cycle, and saved_idx is one higher in the next cycle.
- R4: The number of elements issued but not yet written back never exceeds WIN. When WIN elements are outstanding, issue stalls until a writeback frees a slot.
- R5: In any cycle where intr_req is high, iss_valid is low.
- R6: An intr_req seen in ST_RUN always gives a one-cycle flush pulse on the next cycle, then a one-cycle intr_ack on the cycle after. This holds even with a full window. Uncommitted elements are dropped. No writeback or issue happens between the request and the acknowledge. saved_idx then holds the first uncommitted index.
- R7: done pulses for one cycle, in the cycle after element VL-1 is written back. A start with length 0 gives done with no issue.
- R8: resume with resume_idx below the length continues from that element, and the remaining elements are each written back once. resume with resume_idx at or past the length gives done with no issue.
- R9: A completion is ignored if its slot holds no outstanding element, if it targets a slot already completed, or if it arrives outside ST_RUN.
- R10: A completion that arrives before those of lower-indexed elements is held in its slot until all lower elements are written back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a vector at element 0 (idle only) |
| resume | input | 1 | Continue a vector from resume_idx (idle only) |
| vl_in | input | IDX_W | Vector length, sampled on start or resume |
| resume_idx | input | IDX_W | Element index to resume from |
| iss_valid | output | 1 | An element operation is offered to the pipeline |
| iss_ready | input | 1 | Pipeline accepts the offered operation |
| iss_idx | output | IDX_W | Index of the offered element |
| iss_slot | output | SLOT_W | Window slot tag of the offered element |
| cmp_valid | input | 1 | A result returns from the pipeline |
| cmp_slot | input | SLOT_W | Slot tag of the returning result |
| cmp_data | input | DATA_W | Result data |
| wb_valid | output | 1 | Write one result to the register file this cycle |
| wb_idx | output | IDX_W | Element index being written |
| wb_data | output | DATA_W | Data being written |
| intr_req | input | 1 | Interrupt or cancel request (level, held until acknowledge) |
| flush | output | 1 | Pipelines must drop all outstanding element work |
| intr_ack | output | 1 | Rollback finished; the interrupt may proceed |
| saved_idx | output | IDX_W | Commit index, the context value for resume |
| done | output | 1 | One-cycle pulse when the vector completes |
| busy | output | 1 | Block is not idle |

## Verification
The bench first holds back all completions, so the window fills, and confirms that issue stops at exactly WIN outstanding elements. A design that miscounts occupancy would overrun the window or stall early. It then returns results in scrambled order. A design that retired eagerly would write back out of order or with holes, and the scoreboard would see an unexpected index. Interrupts are raised mid-vector and again with a full, uncompleted window. A design that committed speculatively, or reported the issue index rather than the commit index, would resume past lost elements, and the scoreboard would be left with unmatched entries. A stray completion aimed at an empty slot would corrupt data if it were accepted.

// File: rtl/vseq_pkg.sv
package vseq_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RUN,
        ST_FLUSH,
        ST_ACK,
        ST_FINISH
    } seq_state_e;
endpackage

// File: rtl/vseq_window.sv
// Slot window: one valid and one done flag per slot, plus a result register.
module vseq_window #(
    parameter int WIN    = 8,
    parameter int DATA_W = 16,
    parameter int SLOT_W = $clog2(WIN)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              alloc,
    input  logic [SLOT_W-1:0] alloc_slot,
    input  logic              cmp_en,
    input  logic              cmp_valid,
    input  logic [SLOT_W-1:0] cmp_slot,
    input  logic [DATA_W-1:0] cmp_data,
    input  logic [SLOT_W-1:0] head_slot,
    input  logic              retire,
    output logic              head_ready,
    output logic [DATA_W-1:0] head_data
);
    logic [WIN-1:0]    slot_vld;
    logic [WIN-1:0]    slot_dn;
    logic [DATA_W-1:0] slot_data [WIN];
    logic              cmp_hit;

    // A completion counts only for an outstanding, not-yet-completed slot.
    assign cmp_hit = cmp_en && cmp_valid && slot_vld[cmp_slot] && !slot_dn[cmp_slot];

    for (genvar g = 0; g < WIN; g++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slot_vld[g]  <= 1'b0;
                slot_dn[g]   <= 1'b0;
                slot_data[g] <= '0;
            end else if (clear) begin
                slot_vld[g] <= 1'b0;
                slot_dn[g]  <= 1'b0;
            end else begin
                if (alloc && alloc_slot == SLOT_W'(g)) begin
                    slot_vld[g] <= 1'b1;
                    slot_dn[g]  <= 1'b0;
                end else if (retire && head_slot == SLOT_W'(g)) begin
                    slot_vld[g] <= 1'b0;
                    slot_dn[g]  <= 1'b0;
                end else if (cmp_hit && cmp_slot == SLOT_W'(g)) begin
                    slot_dn[g] <= 1'b1;
                end
                if (cmp_hit && cmp_slot == SLOT_W'(g)) begin
                    slot_data[g] <= cmp_data;
                end
            end
        end
    end

    assign head_ready = slot_vld[head_slot] && slot_dn[head_slot];
    assign head_data  = slot_data[head_slot];
endmodule

// File: rtl/vseq_ctrl.sv
// Sequencing state machine with the issue, commit and length counters.
module vseq_ctrl
    import vseq_pkg::*;
#(
    parameter int MAX_VL = 64,
    parameter int WIN    = 8,
    parameter int IDX_W  = $clog2(MAX_VL + 1),
    parameter int SLOT_W = $clog2(WIN)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              resume,
    input  logic [IDX_W-1:0]  vl_in,
    input  logic [IDX_W-1:0]  resume_idx,
    input  logic              intr_req,
    input  logic              iss_ready,
    input  logic              head_ready,
    output logic              iss_valid,
    output logic [IDX_W-1:0]  iss_idx,
    output logic [SLOT_W-1:0] iss_slot,
    output logic [SLOT_W-1:0] head_slot,
    output logic              wb_valid,
    output logic [IDX_W-1:0]  wb_idx,
    output logic [IDX_W-1:0]  commit_idx,
    output logic              win_clear,
    output logic              cmp_en,
    output logic              flush,
    output logic              intr_ack,
    output logic              done,
    output logic              busy
);
    localparam logic [IDX_W-1:0] VL_CAP  = IDX_W'(MAX_VL);
    localparam logic [IDX_W-1:0] WIN_CNT = IDX_W'(WIN);

    seq_state_e       state_q, state_d;
    logic [IDX_W-1:0] vl_q, nidx_q, cidx_q;
    logic [IDX_W-1:0] vl_eff, in_flight;
    logic             iss_fire, last_commit;

    assign vl_eff      = (vl_in > VL_CAP) ? VL_CAP : vl_in;
    assign in_flight   = IDX_W'(nidx_q - cidx_q);
    assign iss_fire    = iss_valid && iss_ready;
    assign last_commit = wb_valid && (IDX_W'(cidx_q + IDX_W'(1)) == vl_q);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start)       state_d = (vl_eff == '0) ? ST_FINISH : ST_RUN;
                else if (resume) state_d = (resume_idx >= vl_eff) ? ST_FINISH : ST_RUN;
            end
            ST_RUN: begin
                if (intr_req)         state_d = ST_FLUSH;
                else if (last_commit) state_d = ST_FINISH;
            end
            ST_FLUSH:  state_d = ST_ACK;
            ST_ACK:    state_d = ST_IDLE;
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // Counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vl_q   <= '0;
            nidx_q <= '0;
            cidx_q <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        vl_q   <= vl_eff;
                        nidx_q <= '0;
                        cidx_q <= '0;
                    end else if (resume) begin
                        vl_q   <= vl_eff;
                        nidx_q <= resume_idx;
                        cidx_q <= resume_idx;
                    end
                end
                ST_RUN: begin
                    if (iss_fire) nidx_q <= IDX_W'(nidx_q + IDX_W'(1));
                    if (wb_valid) cidx_q <= IDX_W'(cidx_q + IDX_W'(1));
                end
                ST_FLUSH: nidx_q <= cidx_q;
                ST_ACK, ST_FINISH: ;
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        iss_valid = 1'b0;
        wb_valid  = 1'b0;
        cmp_en    = 1'b0;
        flush     = 1'b0;
        intr_ack  = 1'b0;
        done      = 1'b0;
        win_clear = 1'b0;
        busy      = 1'b1;
        unique case (state_q)
            ST_IDLE: begin
                busy      = 1'b0;
                win_clear = start || resume;
            end
            ST_RUN: begin
                cmp_en    = 1'b1;
                wb_valid  = head_ready;
                iss_valid = !intr_req && (nidx_q < vl_q) && (in_flight < WIN_CNT);
            end
            ST_FLUSH: begin
                flush     = 1'b1;
                win_clear = 1'b1;
            end
            ST_ACK:    intr_ack = 1'b1;
            ST_FINISH: done     = 1'b1;
            default:   busy     = 1'b0;
        endcase
    end

    assign iss_idx    = nidx_q;
    assign iss_slot   = nidx_q[SLOT_W-1:0];
    assign head_slot  = cidx_q[SLOT_W-1:0];
    assign wb_idx     = cidx_q;
    assign commit_idx = cidx_q;
endmodule

// File: rtl/vec_elem_seq.sv
module vec_elem_seq #(
    parameter int MAX_VL = 64,
    parameter int WIN    = 8,
    parameter int DATA_W = 16,
    parameter int IDX_W  = $clog2(MAX_VL + 1),
    parameter int SLOT_W = $clog2(WIN)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              resume,
    input  logic [IDX_W-1:0]  vl_in,
    input  logic [IDX_W-1:0]  resume_idx,
    output logic              iss_valid,
    input  logic              iss_ready,
    output logic [IDX_W-1:0]  iss_idx,
    output logic [SLOT_W-1:0] iss_slot,
    input  logic              cmp_valid,
    input  logic [SLOT_W-1:0] cmp_slot,
    input  logic [DATA_W-1:0] cmp_data,
    output logic              wb_valid,
    output logic [IDX_W-1:0]  wb_idx,
    output logic [DATA_W-1:0] wb_data,
    input  logic              intr_req,
    output logic              flush,
    output logic              intr_ack,
    output logic [IDX_W-1:0]  saved_idx,
    output logic              done,
    output logic              busy
);
    logic              win_clear, cmp_en, head_ready;
    logic [SLOT_W-1:0] head_slot;

    vseq_ctrl #(
        .MAX_VL (MAX_VL),
        .WIN    (WIN),
        .IDX_W  (IDX_W),
        .SLOT_W (SLOT_W)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .resume     (resume),
        .vl_in      (vl_in),
        .resume_idx (resume_idx),
        .intr_req   (intr_req),
        .iss_ready  (iss_ready),
        .head_ready (head_ready),
        .iss_valid  (iss_valid),
        .iss_idx    (iss_idx),
        .iss_slot   (iss_slot),
        .head_slot  (head_slot),
        .wb_valid   (wb_valid),
        .wb_idx     (wb_idx),
        .commit_idx (saved_idx),
        .win_clear  (win_clear),
        .cmp_en     (cmp_en),
        .flush      (flush),
        .intr_ack   (intr_ack),
        .done       (done),
        .busy       (busy)
    );

    vseq_window #(
        .WIN    (WIN),
        .DATA_W (DATA_W),
        .SLOT_W (SLOT_W)
    ) u_win (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (win_clear),
        .alloc      (iss_valid && iss_ready),
        .alloc_slot (iss_slot),
        .cmp_en     (cmp_en),
        .cmp_valid  (cmp_valid),
        .cmp_slot   (cmp_slot),
        .cmp_data   (cmp_data),
        .head_slot  (head_slot),
        .retire     (wb_valid),
        .head_ready (head_ready),
        .head_data  (wb_data)
    );
endmodule

// File: rtl/vseq_checker.sv
module vseq_checker #(
    parameter int WIN   = 8,
    parameter int IDX_W = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             iss_valid,
    input logic [IDX_W-1:0] iss_idx,
    input logic             wb_valid,
    input logic [IDX_W-1:0] wb_idx,
    input logic [IDX_W-1:0] saved_idx,
    input logic             intr_req,
    input logic             flush,
    input logic             intr_ack,
    input logic             done,
    input logic             busy
);
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!iss_valid && !wb_valid && !flush && !intr_ack)); // R1

    AST_WB_AT_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> (wb_idx == saved_idx)); // R3

    AST_WB_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |=> (saved_idx == IDX_W'($past(saved_idx) + IDX_W'(1)))); // R3

    AST_WIN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid |-> (IDX_W'(iss_idx - saved_idx) < IDX_W'(WIN))); // R4

    AST_NO_ISSUE_ON_INTR: assert property (@(posedge clk) disable iff (!rst_n)
        intr_req |-> !iss_valid); // R5

    AST_ACK_FOLLOWS_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (intr_ack && !flush)); // R6

    AST_ACK_NEEDS_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        intr_ack |-> $past(flush)); // R6

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R7
endmodule

bind vec_elem_seq vseq_checker #(
    .WIN   (WIN),
    .IDX_W (IDX_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .iss_valid (iss_valid),
    .iss_idx   (iss_idx),
    .wb_valid  (wb_valid),
    .wb_idx    (wb_idx),
    .saved_idx (saved_idx),
    .intr_req  (intr_req),
    .flush     (flush),
    .intr_ack  (intr_ack),
    .done      (done),
    .busy      (busy)
);

// File: tb/sim_vec_elem_seq.sv
module sim_vec_elem_seq;
    localparam int CLK_PERIOD = 10;
    localparam int MAX_VL = 64;
    localparam int WIN    = 8;
    localparam int DATA_W = 16;
    localparam int IDX_W  = 7;
    localparam int SLOT_W = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0, resume = 1'b0;
    logic [IDX_W-1:0]  vl_in = '0, resume_idx = '0;
    logic              iss_valid, iss_ready = 1'b0;
    logic [IDX_W-1:0]  iss_idx;
    logic [SLOT_W-1:0] iss_slot;
    logic              cmp_valid = 1'b0;
    logic [SLOT_W-1:0] cmp_slot = '0;
    logic [DATA_W-1:0] cmp_data = '0;
    logic              wb_valid;
    logic [IDX_W-1:0]  wb_idx;
    logic [DATA_W-1:0] wb_data;
    logic              intr_req = 1'b0;
    logic              flush, intr_ack, done, busy;
    logic [IDX_W-1:0]  saved_idx;

    vec_elem_seq #(.MAX_VL(MAX_VL), .WIN(WIN), .DATA_W(DATA_W)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .resume(resume),
        .vl_in(vl_in), .resume_idx(resume_idx),
        .iss_valid(iss_valid), .iss_ready(iss_ready), .iss_idx(iss_idx), .iss_slot(iss_slot),
        .cmp_valid(cmp_valid), .cmp_slot(cmp_slot), .cmp_data(cmp_data),
        .wb_valid(wb_valid), .wb_idx(wb_idx), .wb_data(wb_data),
        .intr_req(intr_req), .flush(flush), .intr_ack(intr_ack),
        .saved_idx(saved_idx), .done(done), .busy(busy)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_tests = 0, n_fail = 0;
    int sb_q[$];
    bit pend_v[WIN];
    int pend_idx[WIN];
    int exp_iss = 0, next_wb = 0, max_inflight = 0, ooo_cnt = 0;
    int cyc = 0, last_wb_cyc = -10, done_cyc = -10, wb_total = 0, iss_total = 0;
    int iss_during_intr = 0;
    bit done_seen = 0, ack_seen = 0, flush_seen = 0;
    bit cmp_enable = 0, go_start = 0, go_resume = 0, intr_drive = 0;
    bit force_cmp = 0;
    int ready_mode = 0;             // 0 always, 1 pseudo-random, 2 never
    int op_vl = 0, op_res = 0;
    logic [SLOT_W-1:0] force_slot = '0;
    logic [15:0] lfsr = 16'hACE1;

    function automatic logic [DATA_W-1:0] exp_data(int idx);
        return DATA_W'(idx * 37 + 16'h1234);
    endfunction

    task automatic check(bit ok, string req, string what, int act, int expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s act=%0d exp=%0d", req, what, act, expv);
        end
    endtask

    // Driver: one clock cycle of stimulus and issue observation
    task automatic step();
        @(negedge clk);
        cyc++;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        start  = go_start;   go_start  = 0;
        resume = go_resume;  go_resume = 0;
        vl_in      = IDX_W'(op_vl);
        resume_idx = IDX_W'(op_res);
        intr_req   = intr_drive;
        iss_ready  = (ready_mode == 0) ? 1'b1 : (ready_mode == 1) ? lfsr[5] : 1'b0;
        cmp_valid  = 1'b0;
        if (force_cmp) begin
            cmp_valid = 1'b1; cmp_slot = force_slot; cmp_data = 16'hDEAD;
            force_cmp = 0;
        end else if (cmp_enable) begin
            for (int k = 0; k < WIN; k++) begin
                int s;
                s = (int'(lfsr[2:0]) + k) % WIN;
                if (pend_v[s]) begin
                    for (int j = 0; j < WIN; j++)
                        if (pend_v[j] && pend_idx[j] < pend_idx[s]) begin ooo_cnt++; break; end
                    cmp_valid = 1'b1; cmp_slot = SLOT_W'(s); cmp_data = exp_data(pend_idx[s]);
                    pend_v[s] = 0;
                    break;
                end
            end
        end
        #1;
        if (intr_req && iss_valid) iss_during_intr++;
        if (iss_valid && iss_ready) begin
            check(int'(iss_idx) == exp_iss, "R2", "iss_idx", int'(iss_idx), exp_iss);
            check(int'(iss_slot) == exp_iss % WIN, "R2", "iss_slot", int'(iss_slot), exp_iss % WIN);
            pend_v[iss_slot] = 1; pend_idx[iss_slot] = int'(iss_idx);
            exp_iss++; iss_total++;
            if (exp_iss - next_wb > max_inflight) max_inflight = exp_iss - next_wb;
        end
        if (flush) begin
            flush_seen = 1;
            for (int k = 0; k < WIN; k++) pend_v[k] = 0;
        end
        if (intr_ack) ack_seen = 1;
        if (done) begin done_seen = 1; done_cyc = cyc; end
    endtask

    // Monitor: compare every writeback against the scoreboard
    always @(negedge clk) begin
        #2;
        if (rst_n && wb_valid) begin
            wb_total++;
            last_wb_cyc = cyc;
            if (sb_q.size() == 0) begin
                check(0, "R3", "unexpected wb_idx", int'(wb_idx), -1);
            end else begin
                int e;
                e = sb_q.pop_front();
                check(int'(wb_idx) == e, "R3", "wb_idx order", int'(wb_idx), e);
                check(wb_data == exp_data(e), "R3", "wb_data", int'(wb_data), int'(exp_data(e)));
                next_wb = e + 1;
            end
        end
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog expired act=%0d exp=%0d", cyc, 0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    task automatic clear_flags();
        done_seen = 0; ack_seen = 0; flush_seen = 0; iss_during_intr = 0;
        max_inflight = 0; ooo_cnt = 0; iss_total = 0;
    endtask

    task automatic launch(int vl);
        clear_flags();
        op_vl = vl; exp_iss = 0; next_wb = 0;
        for (int i = 0; i < vl && i < MAX_VL; i++) sb_q.push_back(i);
        go_start = 1;
    endtask

    task automatic relaunch(int vl, int idx);
        clear_flags();
        op_vl = vl; op_res = idx; exp_iss = idx; next_wb = idx;
        go_resume = 1;
    endtask

    task automatic wait_done(int limit);
        for (int i = 0; i < limit && !done_seen; i++) step();
    endtask

    task automatic take_intr(string req);
        int n;
        intr_drive = 1;
        n = 0;
        while (!ack_seen && n < 6) begin step(); n++; end
        check(ack_seen && n == 3, req, "ack latency in cycles", n, 3);
        check(flush_seen, req, "flush before ack", int'(flush_seen), 1);
        #3;
        check(int'(saved_idx) == next_wb, req, "saved_idx at ack", int'(saved_idx), next_wb);
        intr_drive = 0;
    endtask

    initial begin
        int wb_before;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        step();
        // Reset state
        check(!busy && !iss_valid && !wb_valid && !done && !flush && !intr_ack,
              "R1", "idle outputs", int'(busy), 0);
        check(saved_idx == '0, "R1", "saved_idx after reset", int'(saved_idx), 0);

        // Length zero
        launch(0);
        for (int i = 0; i < 4; i++) step();
        check(done_seen, "R7", "done for VL=0", int'(done_seen), 1);
        check(iss_total == 0, "R7", "issues for VL=0", iss_total, 0);

        // Short vector, in-order friendly
        cmp_enable = 1; ready_mode = 0;
        launch(5);
        wait_done(200);
        check(done_seen, "R7", "done for VL=5", int'(done_seen), 1);
        check(done_cyc == last_wb_cyc + 1, "R7", "done cycle after last wb", done_cyc, last_wb_cyc + 1);
        check(next_wb == 5 && sb_q.size() == 0, "R3", "all committed VL=5", next_wb, 5);
        step();
        check(!busy, "R1", "idle after done", int'(busy), 0);

        // Window fill and stall, then scrambled completion
        cmp_enable = 0; ready_mode = 0;
        launch(40);
        for (int i = 0; i < 20; i++) step();
        check(exp_iss == WIN, "R4", "issued while stalled", exp_iss, WIN);
        check(max_inflight == WIN, "R4", "peak in flight", max_inflight, WIN);
        cmp_enable = 1; ready_mode = 1;
        wait_done(2000);
        check(done_seen && sb_q.size() == 0, "R10", "scrambled run complete", sb_q.size(), 0);
        check(ooo_cnt > 0, "R10", "out-of-order completions seen", ooo_cnt, 1);
        check(max_inflight <= WIN, "R4", "peak bound", max_inflight, WIN);

        // Interrupt mid-vector, then resume
        cmp_enable = 1; ready_mode = 0;
        launch(70);                        // clamps to MAX_VL
        for (int i = 0; i < 30; i++) step();
        take_intr("R6");
        check(iss_during_intr == 0, "R5", "issues while intr_req high", iss_during_intr, 0);
        wb_before = wb_total;
        for (int i = 0; i < 5; i++) step();
        check(wb_total == wb_before && !busy, "R6", "quiet after ack", wb_total - wb_before, 0);
        relaunch(MAX_VL, int'(saved_idx));
        wait_done(2000);
        check(done_seen && sb_q.size() == 0, "R8", "resumed vector complete", sb_q.size(), 0);
        check(next_wb == MAX_VL, "R2", "clamped length", next_wb, MAX_VL);

        // Interrupt with a full window and no completions
        cmp_enable = 0; ready_mode = 0;
        launch(12);
        for (int i = 0; i < 15; i++) step();
        take_intr("R6");
        check(saved_idx == '0, "R6", "rollback to zero", int'(saved_idx), 0);
        step();
        cmp_enable = 1;
        relaunch(12, 0);
        wait_done(500);
        check(done_seen && sb_q.size() == 0, "R8", "resume from zero complete", sb_q.size(), 0);

        // Resume at the end of the vector
        relaunch(10, 10);
        for (int i = 0; i < 4; i++) step();
        check(done_seen && iss_total == 0, "R8", "resume at end issues", iss_total, 0);

        // Stray completions are ignored
        cmp_enable = 0; ready_mode = 2;
        force_slot = 3'd1; force_cmp = 1;
        step();                            // in idle
        launch(3);
        for (int i = 0; i < 3; i++) step();
        force_slot = 3'd2; force_cmp = 1;  // slot holds nothing yet
        step();
        ready_mode = 0;
        for (int i = 0; i < 3; i++) step();
        check(exp_iss == 3 && wb_total == 0 + wb_total, "R9", "issued before completions", exp_iss, 3);
        wb_before = wb_total;
        for (int i = 0; i < 3; i++) step();
        check(wb_total == wb_before, "R9", "no wb without completion", wb_total - wb_before, 0);
        cmp_enable = 1;
        wait_done(200);
        check(done_seen && sb_q.size() == 0 && next_wb == 3, "R9", "stray data not committed", next_wb, 3);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule